// File: doc/BRIEF.md
# Paged NIC Register Bank

This block is the host-facing control register file of a small Ethernet controller, with its interrupt logic. A byte-wide register bus with a 4-bit offset reaches it. Offset 0 always holds the command byte. The two top bits of the command byte pick a page, and that page decides what offsets 1 to 15 mean. On page 0 a read and a write at the same offset reach different registers. Page 2 gives read access to several registers that page 0 can only write.

The bank holds the interrupt status byte and the interrupt mask byte. The status bits are set by one-cycle event pulses from the neighbouring receive, transmit and DMA blocks, and by a transmit request in the command byte. Software clears them by writing a 1 to each bit it wants cleared. A registered, level-sensitive interrupt output follows the masked status. Bit 7 of the status byte means "reset in progress" and never raises the interrupt. The ring pointers, the transfer addresses and counts, the configuration bytes, the station address and the multicast hash are all driven out as ports for the other blocks.

Top module: `nic_regbank`

## Requirements
- R1: After reset the command byte is 0x22, the status byte is 0x80, the mask is 0x00 and the interrupt output is low. All other registers are 0, including the station address and the multicast hash.
- R2: Offset 0 reads and writes the command byte on every page. Command bits 7:6 select the page, bit 0 is stop and bit 2 is transmit request.
- R3: Page 0 writes map as follows. Offset 1 is ring start, 2 ring stop, 3 boundary, 4 transmit start page, 5/6 the low/high transmit byte count, 7 the status-clear byte, 8/9 the low/high remote start address, A/B the low/high remote byte count, C receive config, D transmit config, E data config and F mask. Each value appears on its output port.
- R4: Page 0 reads return the boundary at offset 3, the transmit status at offset 4 and the status byte at offset 7. Every other page 0 offset from 1 to 15 reads 0x00.
- R5: On page 1, offsets 1–6 read and write station address bytes 0–5 (byte i on macAddr[8i+7:8i]). Offset 7 reads and writes the current page. Offsets 8–F read and write multicast hash bytes 0–7 (byte j on mcastHash[8j+7:8j]).
- R6: On page 2, reads return ring start (1), ring stop (2), transmit start page (4), receive config (C), transmit config (D), data config (E) and mask (F). Every other page 2 offset reads 0x00. Writes at offsets 1–15 on pages 2 and 3 change nothing, and page 3 reads 0x00 at offsets 1–15.
- R7: A status write clears each of bits 6:0 whose bit in the written byte is 1. It never changes bit 7.
- R8: A 1 on evtSet[k] (k = 0..6) sets status bit k on the next edge. A set wins over a clear of the same bit in the same cycle.
- R9: irqOut is a register. One cycle after the status and mask registers change, it equals the OR over bits 6:0 of (status AND mask). Bit 7 never raises it.
- R10: A command write with bit 0 clear clears status bit 7. A command write with bit 0 set leaves status bit 7 unchanged.
- R11: A command write with bit 0 clear and bit 2 set does three things: it sets the transmit status to 0x01, it sets status bit 1, and it stores the command with bit 2 cleared. With bit 0 set, the command is stored exactly as written and nothing else happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 4 | Register offset |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for regAddr on the current page |
| evtSet | input | 7 | Event pulses that set status bits 6:0 |
| irqOut | output | 1 | Registered level interrupt |
| cmdOut | output | 8 | Command byte |
| ringStartPg | output | 8 | Receive ring start page |
| ringStopPg | output | 8 | Receive ring stop page |
| boundaryPg | output | 8 | Boundary page |
| txStartPg | output | 8 | Transmit start page |
| txByteCnt | output | 16 | Transmit byte count |
| remStartAddr | output | 16 | Remote DMA start address |
| remByteCnt | output | 16 | Remote DMA byte count |
| rxCfg | output | 8 | Receive configuration |
| txCfg | output | 8 | Transmit configuration |
| dataCfg | output | 8 | Data configuration |
| curPg | output | 8 | Current receive page |
| macAddr | output | 48 | Station address, byte 0 lowest |
| mcastHash | output | 64 | Multicast hash, byte 0 lowest |

## Verification
The assertions assume that evtSet is quiet whenever they check the result of a status-clear write. They also assume that a command write and a status write never fall in the same cycle. The second holds for any single-port bus, since a cycle carries one offset. The bench drives evtSet only in dedicated pulse cycles, except for the two cases that test a set and a clear together. Those two cases are checked at the ports and do not rely on the clear assertion. The bus carries one access per cycle and never presents X after reset.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;
  localparam int REG_ADDR_W  = 4;
  localparam int REG_DATA_W  = 8;
  localparam int NUM_OFFS    = 1 << REG_ADDR_W;
  localparam int MAC_BYTES   = 6;
  localparam int MCAST_BYTES = 8;
  localparam int MAC_BASE    = 1;
  localparam int CURPG_OFF   = MAC_BASE + MAC_BYTES;
  localparam int MCAST_BASE  = CURPG_OFF + 1;
  localparam int STAT_BITS   = REG_DATA_W - 1;

  // page 0 write offsets
  localparam int OFF_RSTART = 1;
  localparam int OFF_RSTOP  = 2;
  localparam int OFF_BOUND  = 3;
  localparam int OFF_TXPG   = 4;
  localparam int OFF_TCLO   = 5;
  localparam int OFF_TCHI   = 6;
  localparam int OFF_STATUS = 7;
  localparam int OFF_RALO   = 8;
  localparam int OFF_RAHI   = 9;
  localparam int OFF_RCLO   = 10;
  localparam int OFF_RCHI   = 11;
  localparam int OFF_RXCFG  = 12;
  localparam int OFF_TXCFG  = 13;
  localparam int OFF_DCFG   = 14;
  localparam int OFF_MASK   = 15;

  localparam logic [REG_DATA_W-1:0] CMD_RESET  = 8'h22;
  localparam logic [REG_DATA_W-1:0] STAT_RESET = 8'h80;

  typedef struct packed {
    logic                cmdWr;
    logic [NUM_OFFS-1:0] p0Wr;
    logic [NUM_OFFS-1:0] p1Wr;
  } ctrlStrobes_t;
endpackage

// File: rtl/nic_regbank_ctrl.sv
module nic_regbank_ctrl
  import nic_regbank_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [1:0]            pageSel,
  output ctrlStrobes_t          strobes
);
  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      if (regAddr == '0) begin
        strobes.cmdWr = 1'b1;
      end else begin
        case (pageSel)
          2'd0:    strobes.p0Wr[regAddr] = 1'b1;
          2'd1:    strobes.p1Wr[regAddr] = 1'b1;
          default: ; // pages 2 and 3: writes ignored
        endcase
      end
    end
  end
endmodule

// File: rtl/nic_regbank_dp.sv
module nic_regbank_dp
  import nic_regbank_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobes,
  input  logic [REG_ADDR_W-1:0]     regAddr,
  input  logic [REG_DATA_W-1:0]     regWdata,
  input  logic [STAT_BITS-1:0]      evtSet,
  output logic [REG_DATA_W-1:0]     regRdata,
  output logic [1:0]                pageSel,
  output logic                      irqOut,
  output logic [REG_DATA_W-1:0]     cmdOut,
  output logic [REG_DATA_W-1:0]     ringStartPg,
  output logic [REG_DATA_W-1:0]     ringStopPg,
  output logic [REG_DATA_W-1:0]     boundaryPg,
  output logic [REG_DATA_W-1:0]     txStartPg,
  output logic [2*REG_DATA_W-1:0]   txByteCnt,
  output logic [2*REG_DATA_W-1:0]   remStartAddr,
  output logic [2*REG_DATA_W-1:0]   remByteCnt,
  output logic [REG_DATA_W-1:0]     rxCfg,
  output logic [REG_DATA_W-1:0]     txCfg,
  output logic [REG_DATA_W-1:0]     dataCfg,
  output logic [REG_DATA_W-1:0]     curPg,
  output logic [MAC_BYTES*REG_DATA_W-1:0]   macAddr,
  output logic [MCAST_BYTES*REG_DATA_W-1:0] mcastHash
);
  logic [REG_DATA_W-1:0] cmdReg, cmdNext, statusReg, statusNext, maskReg, txStatus;
  logic [REG_DATA_W-1:0] macBytes   [MAC_BYTES];
  logic [REG_DATA_W-1:0] mcastBytes [MCAST_BYTES];
  logic                  txFire, runWr;

  assign runWr  = strobes.cmdWr && !regWdata[0];
  assign txFire = runWr && regWdata[2];

  always_comb begin
    statusNext = statusReg;
    if (strobes.p0Wr[OFF_STATUS])
      statusNext[STAT_BITS-1:0] = statusReg[STAT_BITS-1:0] & ~regWdata[STAT_BITS-1:0];
    if (runWr) statusNext[STAT_BITS] = 1'b0;
    if (txFire) statusNext[1] = 1'b1;
    statusNext[STAT_BITS-1:0] = statusNext[STAT_BITS-1:0] | evtSet;
  end

  always_comb begin
    cmdNext = regWdata;
    if (txFire) cmdNext[2] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg    <= CMD_RESET;
      statusReg <= STAT_RESET;
      txStatus  <= '0;
      irqOut    <= 1'b0;
    end else begin
      if (strobes.cmdWr) cmdReg <= cmdNext;
      statusReg <= statusNext;
      if (txFire) txStatus <= 8'h01;
      irqOut <= |(statusReg[STAT_BITS-1:0] & maskReg[STAT_BITS-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringStartPg <= '0; ringStopPg <= '0; boundaryPg <= '0; txStartPg <= '0;
      txByteCnt <= '0; remStartAddr <= '0; remByteCnt <= '0;
      rxCfg <= '0; txCfg <= '0; dataCfg <= '0; maskReg <= '0; curPg <= '0;
    end else begin
      if (strobes.p0Wr[OFF_RSTART]) ringStartPg <= regWdata;
      if (strobes.p0Wr[OFF_RSTOP])  ringStopPg  <= regWdata;
      if (strobes.p0Wr[OFF_BOUND])  boundaryPg  <= regWdata;
      if (strobes.p0Wr[OFF_TXPG])   txStartPg   <= regWdata;
      if (strobes.p0Wr[OFF_TCLO])   txByteCnt[REG_DATA_W-1:0]             <= regWdata;
      if (strobes.p0Wr[OFF_TCHI])   txByteCnt[2*REG_DATA_W-1:REG_DATA_W]  <= regWdata;
      if (strobes.p0Wr[OFF_RALO])   remStartAddr[REG_DATA_W-1:0]          <= regWdata;
      if (strobes.p0Wr[OFF_RAHI])   remStartAddr[2*REG_DATA_W-1:REG_DATA_W] <= regWdata;
      if (strobes.p0Wr[OFF_RCLO])   remByteCnt[REG_DATA_W-1:0]            <= regWdata;
      if (strobes.p0Wr[OFF_RCHI])   remByteCnt[2*REG_DATA_W-1:REG_DATA_W] <= regWdata;
      if (strobes.p0Wr[OFF_RXCFG])  rxCfg   <= regWdata;
      if (strobes.p0Wr[OFF_TXCFG])  txCfg   <= regWdata;
      if (strobes.p0Wr[OFF_DCFG])   dataCfg <= regWdata;
      if (strobes.p0Wr[OFF_MASK])   maskReg <= regWdata;
      if (strobes.p1Wr[CURPG_OFF])  curPg   <= regWdata;
    end
  end

  for (genvar g = 0; g < MAC_BYTES; g++) begin : gMac
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) macBytes[g] <= '0;
      else if (strobes.p1Wr[MAC_BASE+g]) macBytes[g] <= regWdata;
    end
    assign macAddr[g*REG_DATA_W +: REG_DATA_W] = macBytes[g];
  end

  for (genvar g = 0; g < MCAST_BYTES; g++) begin : gMcast
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mcastBytes[g] <= '0;
      else if (strobes.p1Wr[MCAST_BASE+g]) mcastBytes[g] <= regWdata;
    end
    assign mcastHash[g*REG_DATA_W +: REG_DATA_W] = mcastBytes[g];
  end

  assign cmdOut  = cmdReg;
  assign pageSel = cmdReg[REG_DATA_W-1 -: 2];

  always_comb begin
    regRdata = '0;
    if (regAddr == '0) begin
      regRdata = cmdReg;
    end else begin
      case (pageSel)
        2'd0: begin
          case (int'(regAddr))
            OFF_BOUND:  regRdata = boundaryPg;
            OFF_TXPG:   regRdata = txStatus;
            OFF_STATUS: regRdata = statusReg;
            default:    regRdata = '0;
          endcase
        end
        2'd1: begin
          if (int'(regAddr) == CURPG_OFF) regRdata = curPg;
          for (int i = 0; i < MAC_BYTES; i++)
            if (int'(regAddr) == MAC_BASE + i) regRdata = macBytes[i];
          for (int i = 0; i < MCAST_BYTES; i++)
            if (int'(regAddr) == MCAST_BASE + i) regRdata = mcastBytes[i];
        end
        2'd2: begin
          case (int'(regAddr))
            OFF_RSTART: regRdata = ringStartPg;
            OFF_RSTOP:  regRdata = ringStopPg;
            OFF_TXPG:   regRdata = txStartPg;
            OFF_RXCFG:  regRdata = rxCfg;
            OFF_TXCFG:  regRdata = txCfg;
            OFF_DCFG:   regRdata = dataCfg;
            OFF_MASK:   regRdata = maskReg;
            default:    regRdata = '0;
          endcase
        end
        default: regRdata = '0;
      endcase
    end
  end

  // one write target per cycle
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.cmdWr, strobes.p0Wr, strobes.p1Wr}));

  assert_clear_ones_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.p0Wr[OFF_STATUS] && evtSet == '0) |=>
      ((statusReg[STAT_BITS-1:0] & $past(regWdata[STAT_BITS-1:0])) == '0));

  assert_keep_reset_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.p0Wr[OFF_STATUS] |=> $stable(statusReg[STAT_BITS]));

  assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet != '0) |=> ((statusReg[STAT_BITS-1:0] & $past(evtSet)) == $past(evtSet)));

  assert_quiet_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((statusReg[STAT_BITS-1:0] & maskReg[STAT_BITS-1:0]) == '0) |=> !irqOut);

  assert_run_clears_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    runWr |=> !statusReg[STAT_BITS]);

  assert_tx_effects_R11: assert property (@(posedge clk) disable iff (!rstN)
    txFire |=> (statusReg[1] && !cmdReg[2] && txStatus == 8'h01));
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   regAddr,
  input  logic         regWrEn,
  input  logic [7:0]   regWdata,
  output logic [7:0]   regRdata,
  input  logic [6:0]   evtSet,
  output logic         irqOut,
  output logic [7:0]   cmdOut,
  output logic [7:0]   ringStartPg,
  output logic [7:0]   ringStopPg,
  output logic [7:0]   boundaryPg,
  output logic [7:0]   txStartPg,
  output logic [15:0]  txByteCnt,
  output logic [15:0]  remStartAddr,
  output logic [15:0]  remByteCnt,
  output logic [7:0]   rxCfg,
  output logic [7:0]   txCfg,
  output logic [7:0]   dataCfg,
  output logic [7:0]   curPg,
  output logic [47:0]  macAddr,
  output logic [63:0]  mcastHash
);
  ctrlStrobes_t strobes;
  logic [1:0]   pageSel;

  nic_regbank_ctrl uCtrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .pageSel (pageSel),
    .strobes (strobes)
  );

  nic_regbank_dp uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .regAddr      (regAddr),
    .regWdata     (regWdata),
    .evtSet       (evtSet),
    .regRdata     (regRdata),
    .pageSel      (pageSel),
    .irqOut       (irqOut),
    .cmdOut       (cmdOut),
    .ringStartPg  (ringStartPg),
    .ringStopPg   (ringStopPg),
    .boundaryPg   (boundaryPg),
    .txStartPg    (txStartPg),
    .txByteCnt    (txByteCnt),
    .remStartAddr (remStartAddr),
    .remByteCnt   (remByteCnt),
    .rxCfg        (rxCfg),
    .txCfg        (txCfg),
    .dataCfg      (dataCfg),
    .curPg        (curPg),
    .macAddr      (macAddr),
    .mcastHash    (mcastHash)
  );
endmodule

// File: tb/nic_regbank_test.sv
module nic_regbank_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWdata = '0;
  logic [6:0] evtSet = '0;
  logic [7:0] regRdata, cmdOut, ringStartPg, ringStopPg, boundaryPg, txStartPg;
  logic [7:0] rxCfg, txCfg, dataCfg, curPg;
  logic [15:0] txByteCnt, remStartAddr, remByteCnt;
  logic [47:0] macAddr;
  logic [63:0] mcastHash;
  logic irqOut;
  int nRun = 0, nFail = 0;

  always #2 clk = ~clk; // 250 MHz

  nic_regbank uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    chk(tag, {56'd0, regRdata}, {56'd0, exp});
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk);
    evtSet = e;
    @(negedge clk);
    evtSet = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] m, w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 cmdOut", cmdOut, 8'h22);
    rd("R1 cmd read", 0, 8'h22);
    rd("R1 status", 7, 8'h80);
    chk("R1 irq", irqOut, 0);
    chk("R1 ring", {ringStartPg, ringStopPg, boundaryPg, txStartPg}, 0);
    chk("R1 mac", macAddr, 0);
    chk("R1 mcast", mcastHash, 0);
    // R7/R9: bit7 not clearable, never interrupts
    wr(4'hF, 8'hFF);
    wr(7, 8'hFF);
    tick();
    rd("R7 bit7 kept", 7, 8'h80);
    chk("R9 bit7 no irq", irqOut, 0);
    wr(4'hF, 8'h00);
    // R10 / R2
    wr(0, 8'h21);
    rd("R10 stop keeps reset bit", 7, 8'h80);
    rd("R2 cmd readback", 0, 8'h21);
    wr(0, 8'h22);
    rd("R10 run clears reset bit", 7, 8'h00);
    // R3 page 0 writes
    for (int o = 1; o < 16; o++) if (o != 7) wr(4'(o), 8'(8'h10 + o));
    chk("R3 ringStart", ringStartPg, 8'h11);
    chk("R3 ringStop", ringStopPg, 8'h12);
    chk("R3 boundary", boundaryPg, 8'h13);
    chk("R3 txStart", txStartPg, 8'h14);
    chk("R3 txCnt", txByteCnt, 16'h1615);
    chk("R3 remStart", remStartAddr, 16'h1918);
    chk("R3 remCnt", remByteCnt, 16'h1B1A);
    chk("R3 cfg", {rxCfg, txCfg, dataCfg}, 24'h1C1D1E);
    // R4 page 0 reads
    for (int o = 1; o < 16; o++) begin
      if (o == 3) rd("R4 boundary read", 4'(o), 8'h13);
      else rd("R4 page0 read", 4'(o), 8'h00);
    end
    // R6 page 2
    wr(0, 8'h82);
    chk("R2 page2 cmd", cmdOut, 8'h82);
    for (int o = 1; o < 16; o++) begin
      case (o)
        1: rd("R6 p2 rstart", 4'(o), 8'h11);
        2: rd("R6 p2 rstop", 4'(o), 8'h12);
        4: rd("R6 p2 txpg", 4'(o), 8'h14);
        12: rd("R6 p2 rxcfg", 4'(o), 8'h1C);
        13: rd("R6 p2 txcfg", 4'(o), 8'h1D);
        14: rd("R6 p2 dcfg", 4'(o), 8'h1E);
        15: rd("R6 p2 mask", 4'(o), 8'h1F);
        default: rd("R6 p2 zero", 4'(o), 8'h00);
      endcase
    end
    wr(1, 8'hAA);
    wr(4'hF, 8'h00);
    chk("R6 p2 write ignored", ringStartPg, 8'h11);
    rd("R6 p2 mask kept", 4'hF, 8'h1F);
    wr(0, 8'hC2);
    for (int o = 1; o < 16; o++) rd("R6 p3 zero", 4'(o), 8'h00);
    for (int o = 1; o < 16; o++) wr(4'(o), 8'h5A);
    chk("R6 p3 ring kept", ringStartPg, 8'h11);
    chk("R6 p3 mac kept", macAddr, 0);
    chk("R6 p3 mcast kept", mcastHash, 0);
    chk("R6 p3 curPg kept", curPg, 0);
    // R5 page 1
    wr(0, 8'h42);
    for (int o = 1; o < 16; o++) wr(4'(o), 8'(8'h30 + o * 5));
    for (int o = 1; o < 16; o++) rd("R5 p1 readback", 4'(o), 8'(8'h30 + o * 5));
    for (int i = 0; i < 6; i++) chk("R5 mac byte", macAddr[i*8 +: 8], 8'(8'h30 + (i + 1) * 5));
    for (int i = 0; i < 8; i++) chk("R5 mcast byte", mcastHash[i*8 +: 8], 8'(8'h30 + (i + 8) * 5));
    chk("R5 curPg", curPg, 8'h53);
    chk("R5 ring untouched", ringStartPg, 8'h11);
    // R7/R8/R9 sweep on page 0
    wr(0, 8'h02);
    for (int p = 0; p < 128; p++) begin
      pulse(7'(p));
      rd("R8 event set", 7, 8'(p));
      m = 8'((p * 37 + 11) & 8'hFF);
      wr(4'hF, m);
      tick();
      chk("R9 irq level", irqOut, |(8'(p) & m & 8'h7F));
      w = 8'((p * 73 + 5) & 8'hFF);
      wr(7, w);
      rd("R7 clear ones", 7, 8'(p) & ~w & 8'h7F);
      wr(7, 8'hFF);
      rd("R7 clear all", 7, 8'h00);
    end
    // R8 set wins over clear
    wr(4'hF, 8'h00);
    pulse(7'h08);
    @(negedge clk);
    regAddr = 7; regWdata = 8'h08; regWrEn = 1'b1; evtSet = 7'h08;
    @(negedge clk);
    regWrEn = 1'b0; evtSet = '0;
    rd("R8 set wins", 7, 8'h08);
    @(negedge clk);
    regAddr = 7; regWdata = 8'h08; regWrEn = 1'b1; evtSet = 7'h01;
    @(negedge clk);
    regWrEn = 1'b0; evtSet = '0;
    rd("R8 other bit set", 7, 8'h01);
    wr(7, 8'hFF);
    // R11 transmit
    rd("R11 txstatus before", 4, 8'h00);
    wr(0, 8'h06);
    rd("R11 tx bit self-clears", 0, 8'h02);
    rd("R11 status bit1", 7, 8'h02);
    rd("R11 tx status", 4, 8'h01);
    wr(7, 8'hFF);
    wr(0, 8'h05);
    rd("R11 stopped cmd kept", 0, 8'h05);
    rd("R11 stopped no status", 7, 8'h00);
    wr(0, 8'h02);
    wr(4'hF, 8'h02);
    wr(0, 8'h06);
    tick();
    chk("R9 tx irq", irqOut, 1);
    wr(7, 8'h02);
    tick();
    chk("R9 irq drops", irqOut, 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule